// File: doc/BRIEF.md
# Systolic Block Sorter with Ping-Pong Result Memory

The block sorts blocks of up to `N` unsigned 64-bit keys with a chain of `N` identical cells, each holding one register and one greater-than comparator. Keys enter one per clock at the head of the chain. Every cell compares in the same cycle, so the chain does `N` comparisons per clock. A cell keeps the larger of its held key and the arriving key, and hands the smaller key to its neighbour one cycle later. An empty cell always captures the first key that reaches it.

A block closes on the key flagged `in_last`, or on its `N`-th key. The chain then drains for `N` cycles. After that it shifts toward the head one place per cycle, and empty cells refill from the tail. The key at the head is written into one of two result banks, largest first, at addresses 0 upward.

When the last key of a block is written, the controller marks that bank full, switches to the other bank and pulses `done_pulse`. A full bank stays untouched until the reader frees it. New keys are accepted only while the bank the next block will write is free. The reader can therefore drain one bank while the following block loads and sorts.

Top module: `sort_array_top`

## Requirements
- R1: After reset `in_ready` is 1, `done_pulse` is 0 and `bank_full` is 2'b00.
- R2: A key is taken on each rising edge where `in_valid` and `in_ready` are both 1. A block closes on the key that carries `in_last`.
- R3: After the edge that takes the closing key of a block of L keys, `in_ready` is 0 until `done_pulse` rises. `done_pulse` is 1 for exactly one cycle, and it rises N+L cycles after that edge.
- R4: When `done_pulse` is 1, `done_len` equals L. The bank named by `done_bank` holds the block's keys in non-increasing order at addresses 0 to L-1.
- R5: Keys are compared as unsigned 64-bit numbers, so a key with bit 63 set sorts above every key with bit 63 clear.
- R6: The first block after reset goes to bank 0, and later blocks alternate between bank 1 and bank 0.
- R7: `bank_full[b]` becomes 1 in the cycle `done_pulse` names bank b. It becomes 0 after an edge where `free_valid` is 1 and `free_bank` is b. A set on the same edge wins. `in_ready` is 0 while the bank the next block will write is full.
- R8: A block whose N-th key arrives without `in_last` closes on that key.
- R9: Equal keys all appear in the result, each as many times as it was offered.
- R10: A key offered while `in_ready` is 0 is not taken and does not appear in any result.
- R11: `rd_data` shows the word at `rd_addr` of bank `rd_bank` one clock after those inputs are presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A key is offered |
| in_data | input | DATA_W | Key offered |
| in_last | input | 1 | The offered key closes the block |
| in_ready | output | 1 | A key can be taken this cycle |
| free_valid | input | 1 | Release a result bank |
| free_bank | input | 1 | Bank to release |
| rd_bank | input | 1 | Bank to read |
| rd_addr | input | $clog2(N) | Word to read |
| rd_data | output | DATA_W | Read word, one cycle after the address |
| done_pulse | output | 1 | A sorted block has been fully written |
| done_bank | output | 1 | Bank that holds the finished block |
| done_len | output | $clog2(N+1) | Number of keys in the finished block |
| bank_full | output | 2 | Bank holds an unreleased result |

## Verification
The hardest state to reach from the ports is the one where both banks hold unreleased results while keys are still being offered. The stimulus gets there by finishing two blocks without freeing either bank. It then holds `in_valid` high with a marker key for several cycles and checks that the marker never shows up in any result. Freeing one bank lets loading resume, and a one-key block then covers the shortest block length. A block of exactly N keys with no `in_last`, keys with bit 63 set, and repeated keys cover the automatic close, the unsigned comparison and duplicate handling.

// File: rtl/sort_pkg.sv
package sort_pkg;
    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_FLUSH  = 2'd1,
        PH_UNLOAD = 2'd2
    } phase_e;
endpackage

// File: rtl/sort_cell.sv
module sort_cell #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         lin_vld_i,
    input  logic [W-1:0] lin_val_i,
    input  logic         rnb_vld_i,
    input  logic [W-1:0] rnb_val_i,
    output logic         hold_vld_o,
    output logic [W-1:0] hold_val_o,
    output logic         pass_vld_o,
    output logic [W-1:0] pass_val_o
);
    typedef struct packed {
        logic         hv;
        logic [W-1:0] h;
        logic         pv;
        logic [W-1:0] p;
    } cell_s;

    cell_s c_d, c_q;

    always_comb begin
        c_d    = c_q;
        c_d.pv = 1'b0;
        if (shift_i) begin
            // move toward the head; tail refills with whatever the right side holds
            c_d.hv = rnb_vld_i;
            c_d.h  = rnb_val_i;
        end else if (lin_vld_i) begin
            if (!c_q.hv) begin
                c_d.hv = 1'b1;
                c_d.h  = lin_val_i;
            end else if (lin_val_i > c_q.h) begin
                c_d.h  = lin_val_i;
                c_d.pv = 1'b1;
                c_d.p  = c_q.h;
            end else begin
                c_d.pv = 1'b1;
                c_d.p  = lin_val_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign hold_vld_o = c_q.hv;
    assign hold_val_o = c_q.h;
    assign pass_vld_o = c_q.pv;
    assign pass_val_o = c_q.p;

    // a held key never decreases while loading
    assert_hold_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(c_q.hv) && !$past(shift_i) && c_q.hv) |-> (c_q.h >= $past(c_q.h)));
endmodule

// File: rtl/sort_ctrl.sv
module sort_ctrl
    import sort_pkg::*;
#(
    parameter int N     = 128,
    parameter int IDX_W = $clog2(N),
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic             accept_o,
    output logic             shift_o,
    output logic             wr_en_o,
    output logic             wr_bank_o,
    output logic [IDX_W-1:0] wr_addr_o,
    input  logic             free_valid_i,
    input  logic             free_bank_i,
    output logic             done_o,
    output logic             done_bank_o,
    output logic [CNT_W-1:0] done_len_o,
    output logic [1:0]       bank_full_o
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] tmr;
        logic [IDX_W-1:0] idx;
        logic             wsel;
        logic [1:0]       busy;
        logic             done;
        logic             dbank;
        logic [CNT_W-1:0] dlen;
    } ctrl_s;

    ctrl_s r_d, r_q;
    logic  ready, acc;

    always_comb begin
        ready = (r_q.ph == PH_LOAD) && !r_q.busy[r_q.wsel];
        acc   = in_valid && ready;

        r_d      = r_q;
        r_d.done = 1'b0;
        if (free_valid_i) r_d.busy[free_bank_i] = 1'b0;

        unique case (r_q.ph)
            PH_LOAD: begin
                if (acc) begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                    if (in_last || (r_q.cnt == CNT_W'(N - 1))) begin
                        r_d.ph  = PH_FLUSH;
                        r_d.tmr = '0;
                    end
                end
            end
            PH_FLUSH: begin
                r_d.tmr = r_q.tmr + IDX_W'(1);
                if (r_q.tmr == IDX_W'(N - 1)) begin
                    r_d.ph  = PH_UNLOAD;
                    r_d.idx = '0;
                end
            end
            PH_UNLOAD: begin
                r_d.idx = r_q.idx + IDX_W'(1);
                if (CNT_W'(r_q.idx) + CNT_W'(1) == r_q.cnt) begin
                    r_d.ph            = PH_LOAD;
                    r_d.done          = 1'b1;
                    r_d.dbank         = r_q.wsel;
                    r_d.dlen          = r_q.cnt;
                    r_d.cnt           = '0;
                    r_d.busy[r_q.wsel] = 1'b1;
                    r_d.wsel          = ~r_q.wsel;
                end
            end
            default: r_d.ph = PH_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{ph: PH_LOAD, default: '0};
        else        r_q <= r_d;
    end

    assign in_ready    = ready;
    assign accept_o    = acc;
    assign shift_o     = (r_q.ph == PH_UNLOAD);
    assign wr_en_o     = (r_q.ph == PH_UNLOAD);
    assign wr_bank_o   = r_q.wsel;
    assign wr_addr_o   = r_q.idx;
    assign done_o      = r_q.done;
    assign done_bank_o = r_q.dbank;
    assign done_len_o  = r_q.dlen;
    assign bank_full_o = r_q.busy;

    assert_close_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_last) |=> !in_ready);
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !bank_full_o[wr_bank_o]);
    assert_done_marks_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> bank_full_o[done_bank_o]);
endmodule

// File: rtl/pingpong_buf.sv
module pingpong_buf #(
    parameter int W     = 64,
    parameter int N     = 128,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_addr,
    output logic [W-1:0]     rd_data
);
    localparam int DEPTH = 2 * N;
    localparam int AW    = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [W-1:0]  rd_q;
    logic [AW-1:0] wa, ra;

    assign wa = (wr_bank ? AW'(N) : AW'(0)) + AW'(wr_addr);
    assign ra = (rd_bank ? AW'(N) : AW'(0)) + AW'(rd_addr);

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wa] <= wr_data;
        rd_q <= mem_q[ra];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/sort_array_top.sv
module sort_array_top #(
    parameter int DATA_W = 64,
    parameter int N      = 128,
    parameter int IDX_W  = $clog2(N),
    parameter int CNT_W  = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              free_valid,
    input  logic              free_bank,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_pulse,
    output logic              done_bank,
    output logic [CNT_W-1:0]  done_len,
    output logic [1:0]        bank_full
);
    logic              acc, shift, wr_en, wr_bank;
    logic [IDX_W-1:0]  wr_addr;
    logic              hv   [N];
    logic [DATA_W-1:0] hval [N];
    logic              pv   [N];
    logic [DATA_W-1:0] pval [N];

    sort_ctrl #(.N(N), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .accept_o(acc), .shift_o(shift),
        .wr_en_o(wr_en), .wr_bank_o(wr_bank), .wr_addr_o(wr_addr),
        .free_valid_i(free_valid), .free_bank_i(free_bank),
        .done_o(done_pulse), .done_bank_o(done_bank), .done_len_o(done_len),
        .bank_full_o(bank_full)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic              l_vld, r_vld;
        logic [DATA_W-1:0] l_val, r_val;

        if (i == 0) begin : g_head
            assign l_vld = acc;
            assign l_val = in_data;
        end else begin : g_body
            assign l_vld = pv[i-1];
            assign l_val = pval[i-1];
        end

        if (i == N - 1) begin : g_tail
            assign r_vld = 1'b0;
            assign r_val = '0;
            assert_no_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !pv[i]);
        end else begin : g_link
            assign r_vld = hv[i+1];
            assign r_val = hval[i+1];
            assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (hv[i] && hv[i+1]) |-> (hval[i] >= hval[i+1]));
            assert_packed_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !hv[i] |-> !hv[i+1]);
        end

        sort_cell #(.W(DATA_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .shift_i(shift),
            .lin_vld_i(l_vld), .lin_val_i(l_val),
            .rnb_vld_i(r_vld), .rnb_val_i(r_val),
            .hold_vld_o(hv[i]), .hold_val_o(hval[i]),
            .pass_vld_o(pv[i]), .pass_val_o(pval[i])
        );
    end

    pingpong_buf #(.W(DATA_W), .N(N), .IDX_W(IDX_W)) u_buf (
        .clk(clk),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(hval[0]),
        .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assert_write_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> hv[0]);
endmodule

// File: tb/tb_sort_array_top.sv
module tb_sort_array_top;
    localparam int N     = 8;
    localparam int W     = 64;
    localparam int IDX_W = $clog2(N);
    localparam int CNT_W = $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [W-1:0] in_data = '0;
    logic in_ready;
    logic free_valid = 1'b0, free_bank = 1'b0;
    logic rd_bank = 1'b0;
    logic [IDX_W-1:0] rd_addr = '0;
    logic [W-1:0] rd_data;
    logic done_pulse, done_bank;
    logic [CNT_W-1:0] done_len;
    logic [1:0] bank_full;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sort_array_top #(.DATA_W(W), .N(N)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .free_valid(free_valid),
        .free_bank(free_bank), .rd_bank(rd_bank), .rd_addr(rd_addr),
        .rd_data(rd_data), .done_pulse(done_pulse), .done_bank(done_bank),
        .done_len(done_len), .bank_full(bank_full)
    );

    // behavioural reference model
    int         m_phase, m_cnt, m_wait, m_dlen;
    logic [1:0] m_busy;
    logic       m_wsel, m_done, m_dbank;
    logic [W-1:0] m_cur [N];
    logic [W-1:0] exp_mem [2][N];
    int           exp_len [2];

    function automatic bit m_ready();
        return (m_phase == 0) && !m_busy[m_wsel];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_wait = 0; m_busy = 2'b00;
            m_wsel = 1'b0; m_done = 1'b0; m_dbank = 1'b0; m_dlen = 0;
        end else begin
            bit rdy;
            rdy = m_ready();
            m_done = 1'b0;
            if (free_valid) m_busy[free_bank] = 1'b0;
            if (m_phase == 0) begin
                if (in_valid && rdy) begin
                    m_cur[m_cnt] = in_data;
                    m_cnt++;
                    if (in_last || m_cnt == N) begin
                        m_phase = 1;
                        m_wait  = N + m_cnt;
                    end
                end
            end else begin
                m_wait--;
                if (m_wait == 0) begin
                    for (int a = 0; a < m_cnt; a++)
                        for (int b = 0; b + 1 < m_cnt - a; b++)
                            if (m_cur[b] < m_cur[b+1]) begin
                                logic [W-1:0] t;
                                t = m_cur[b]; m_cur[b] = m_cur[b+1]; m_cur[b+1] = t;
                            end
                    for (int k = 0; k < m_cnt; k++) exp_mem[m_wsel][k] = m_cur[k];
                    exp_len[m_wsel] = m_cnt;
                    m_done  = 1'b1;
                    m_dbank = m_wsel;
                    m_dlen  = m_cnt;
                    m_busy[m_wsel] = 1'b1;
                    m_wsel  = ~m_wsel;
                    m_phase = 0;
                    m_cnt   = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(in_ready == m_ready(), "R7", "in_ready", W'(in_ready), W'(m_ready()));
            check(done_pulse == m_done, "R3", "done_pulse", W'(done_pulse), W'(m_done));
            check(bank_full == m_busy, "R7", "bank_full", W'(bank_full), W'(m_busy));
            if (m_done) begin
                check(done_bank == m_dbank, "R6", "done_bank", W'(done_bank), W'(m_dbank));
                check(int'(done_len) == m_dlen, "R4", "done_len", W'(done_len), W'(m_dlen));
            end
        end
    end

    task automatic push(input logic [W-1:0] v, input bit l);
        in_valid = 1'b1; in_data = v; in_last = l;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_pulse) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_bank(input bit b, input string req);
        for (int k = 0; k < exp_len[b]; k++) begin
            rd_bank = b; rd_addr = IDX_W'(k);
            @(negedge clk);
            check(rd_data == exp_mem[b][k], req, "bank word", rd_data, exp_mem[b][k]);
            if (k > 0)
                check(exp_mem[b][k-1] >= rd_data, "R4", "order", rd_data, exp_mem[b][k-1]);
        end
    endtask

    task automatic free(input bit b);
        free_valid = 1'b1; free_bank = b;
        @(negedge clk);
        free_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(in_ready == 1'b1, "R1", "in_ready after reset", W'(in_ready), 1);
        check(done_pulse == 1'b0, "R1", "done after reset", W'(done_pulse), 0);
        check(bank_full == 2'b00, "R1", "bank_full after reset", W'(bank_full), 0);

        // R8, R5: full block without in_last, keys with bit 63 set
        push(64'h0000_0000_0000_0005, 0);
        push(64'h8000_0000_0000_0001, 0);
        push(64'h0000_0000_0000_0003, 0);
        push(64'hFFFF_FFFF_FFFF_FFFF, 0);
        push(64'h0000_0000_0000_0000, 0);
        push(64'h7FFF_FFFF_FFFF_FFFF, 0);
        push(64'h0000_0000_0000_0011, 0);
        push(64'h8000_0000_0000_0000, 0);
        wait_done();
        check(exp_len[0] == N, "R8", "auto-close length", W'(exp_len[0]), W'(N));
        read_bank(0, "R5");

        // R9, R6: short block with duplicates goes to bank 1
        push(64'h42, 0);
        push(64'h10, 0);
        push(64'h42, 0);
        push(64'h10, 0);
        push(64'h42, 1);
        wait_done();
        read_bank(1, "R9");

        // R10: both banks full, offered keys must be dropped
        in_valid = 1'b1; in_data = 64'hDEAD_BEEF_0000_0000; in_last = 1'b1;
        repeat (6) @(negedge clk);
        check(in_ready == 1'b0, "R10", "ready while full", W'(in_ready), 0);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
        check(bank_full == 2'b11, "R7", "both full", W'(bank_full), 3);
        read_bank(0, "R10");
        read_bank(1, "R10");

        // R7: release bank 0, one-key block fills it
        free(0);
        push(64'h1234, 1);
        wait_done();
        check(done_len == CNT_W'(1), "R2", "single key length", W'(done_len), 1);
        read_bank(0, "R11");

        // R6: release bank 1, next block alternates into it
        free(1);
        push(64'h3, 0);
        push(64'h9, 0);
        push(64'h1, 1);
        wait_done();
        read_bank(1, "R4");
        free(0);
        free(1);
        @(negedge clk);
        check(bank_full == 2'b00, "R7", "all freed", W'(bank_full), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule